// File: doc/BRIEF.md
# SPI Power-Up Configuration Sequencer

This block brings an SPI-attached peripheral into a known configuration after power-up, without any processor involvement. A single-cycle start pulse makes it play a fixed 30-command script. Each command goes out as one 16-bit word inside its own chip-select frame, most significant bit first, in SPI mode 0 (clock idles low, data sampled on the rising clock edge). A configurable idle gap keeps chip select high between frames.

The script has four parts. It opens with two dummy reads of register 63. It then writes registers 0 to 17 in ascending order. Next comes the calibration command 0x5500. It closes with nine more dummy reads of register 63. Command words are read 0xC000 | (reg << 8), write 0x8000 | (reg << 8) | data, and calibrate 0x5500. The peripheral answers each command two frames late. For every register write, the sequencer compares the word captured two frames later against the expected echo. The first mismatch is reported with the index of the offending command. A done pulse marks the end of the run.

The control state machine has three states. SQ_IDLE waits for start. SQ_SEND has one word in flight. SQ_GAP holds chip select high between frames. The transitions are:
- SQ_IDLE to SQ_SEND on start.
- SQ_SEND to SQ_GAP when a frame ends and more commands remain.
- SQ_SEND to SQ_IDLE when the last frame ends; done is raised on this transition.
- SQ_GAP to SQ_SEND when the gap counter expires.

The word engine underneath has three states. FE_IDLE waits for a go pulse. FE_LOW is the low half of a clock bit. FE_HIGH is the high half. The engine moves FE_IDLE to FE_LOW on go and FE_LOW to FE_HIGH after half a clock period. From FE_HIGH it returns to FE_LOW for the next bit, or to FE_IDLE after bit 15.

Top module: `spi_cfg_seq`

## Requirements
- R1: While reset is held, and afterwards until start, chip select is high, SCLK, MOSI, done, error and error index are all 0.
- R2: One start pulse produces exactly 30 frames. Frame i carries word 0xFF00 for i in 0,1 and 21..29. It carries 0x5500 for i = 20. For i in 2..19 it carries ((0x80 | (i-2)) << 8) | D(i-2), with D(0..17) = DE 20 28 02 90 00 00 00 2C 11 08 15 36 00 FF FF FF FF (hex).
- R3: Each frame has exactly 16 rising SCLK edges while chip select is low. SCLK is low whenever chip select changes, and bits go out MSB first.
- R4: SCLK runs at CLK_DIV system clocks per bit, high for CLK_DIV/2 and low for CLK_DIV/2. The first rising edge comes CLK_DIV/2 cycles after chip select falls.
- R5: Between consecutive frames of a run, chip select stays high for exactly GAP_CYCLES+2 system clock cycles.
- R6: The word shifted in on MISO during frame k (k >= 2) is checked only when command k-2 is a write. It must equal 0xFF in the upper byte and that write's data byte in the lower byte; otherwise error is set.
- R7: On the first mismatch, error rises and error index takes the command index k-2. Later mismatches change neither, and all 30 frames are still sent.
- R8: Replies captured in frames 0 and 1, and replies to dummy reads and to the calibration command, never set error.
- R9: Done is high for exactly one cycle, one clock after chip select rises at the end of frame 29. Error and error index are final in that cycle and keep their values afterwards.
- R10: A start pulse while a run is in progress is ignored: the run still has 30 frames, one done pulse, and error is not cleared.
- R11: A start accepted in idle clears error and error index on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle pulse that launches the script |
| sclk_o | output | 1 | SPI serial clock, idles low |
| csn_o | output | 1 | Active-low chip select, one frame per command |
| mosi_o | output | 1 | Serial command data, MSB first |
| miso_i | input | 1 | Serial reply data from the peripheral |
| done_o | output | 1 | One-cycle pulse after the last frame |
| error_o | output | 1 | Sticky flag: a write echo did not match |
| err_idx_o | output | 5 | Script index of the first command whose echo failed |

## Verification
The bench builds the sequencer with CLK_DIV = 4 and GAP_CYCLES = 3. A whole 30-frame run then takes about two thousand cycles, so a dozen complete runs fit comfortably. The short divider and gap still exercise every half-period, gap and done-timing relation at cycle precision, because the expected counts are written in terms of the parameters. A peripheral model in the bench echoes each write two frames late, returns random words to dummy reads and calibration, and can corrupt chosen write echoes. This reaches the first and last write, multiple faults, and restarts during a run.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int CMD_W      = 16;
    localparam int SCRIPT_LEN = 30;
    localparam int IDX_W      = $clog2(SCRIPT_LEN);
    localparam int FIRST_WR   = 2;
    localparam int LAST_WR    = 19;
    localparam int CAL_POS    = 20;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_GAP} seq_state_t;
    typedef enum logic [1:0] {FE_IDLE, FE_LOW, FE_HIGH} fe_state_t;

    // Power-up value for peripheral register r (0..17)
    function automatic logic [7:0] reg_init(input int r);
        logic [7:0] v;
        case (r)
            0:  v = 8'hDE;
            1:  v = 8'h20;
            2:  v = 8'h28;
            3:  v = 8'h02;
            4:  v = 8'h90;
            8:  v = 8'h2C;
            9:  v = 8'h11;
            10: v = 8'h08;
            11: v = 8'h15;
            12: v = 8'h36;
            14, 15, 16, 17: v = 8'hFF;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic cfg_is_write(input int i);
        return (i >= FIRST_WR) && (i <= LAST_WR);
    endfunction

    function automatic logic [CMD_W-1:0] cfg_word(input int i);
        logic [CMD_W-1:0] w;
        if (cfg_is_write(i))
            w = {8'h80 | 8'(i - FIRST_WR), reg_init(i - FIRST_WR)};
        else if (i == CAL_POS)
            w = 16'h5500;
        else
            w = 16'hFF00;  // read of register 63, used as filler
        return w;
    endfunction

    function automatic logic [CMD_W-1:0] cfg_echo(input int i);
        return {8'hFF, reg_init(i - FIRST_WR)};
    endfunction

endpackage

// File: rtl/spi_cfg_rom.sv
module spi_cfg_rom
    import spi_cfg_pkg::*;
(
    input  logic [IDX_W-1:0] tx_idx_i,
    input  logic [IDX_W-1:0] chk_idx_i,
    input  logic             chk_en_i,
    input  logic [CMD_W-1:0] rx_i,
    output logic [CMD_W-1:0] tx_word_o,
    output logic             echo_bad_o
);
    always_comb begin
        tx_word_o  = cfg_word(int'(tx_idx_i));
        echo_bad_o = chk_en_i && cfg_is_write(int'(chk_idx_i))
                     && (rx_i != cfg_echo(int'(chk_idx_i)));
    end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_cfg_pkg::*;
#(
    parameter int W       = 16,
    parameter int CLK_DIV = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] tx_i,
    input  logic         miso_i,
    output logic         sclk_o,
    output logic         csn_o,
    output logic         mosi_o,
    output logic         done_o,
    output logic [W-1:0] rx_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(HALF) + 1;
    localparam int BIT_W = $clog2(W);

    fe_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic [W-1:0]     sh_q, rx_q;
    logic             half_end, last_bit;

    assign half_end = (cnt_q == CNT_W'(HALF - 1));
    assign last_bit = (bit_q == BIT_W'(W - 1));
    assign mosi_o   = sh_q[W-1];
    assign rx_o     = rx_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FE_IDLE: if (go_i)     st_d = FE_LOW;
            FE_LOW:  if (half_end) st_d = FE_HIGH;
            FE_HIGH: if (half_end) st_d = last_bit ? FE_IDLE : FE_LOW;
            default:               st_d = FE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FE_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_o  <= 1'b1;
            sclk_o <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                FE_IDLE: if (go_i) begin
                    csn_o <= 1'b0;
                    sh_q  <= tx_i;
                    cnt_q <= '0;
                    bit_q <= '0;
                end
                FE_LOW: if (half_end) begin
                    cnt_q  <= '0;
                    sclk_o <= 1'b1;
                    rx_q   <= {rx_q[W-2:0], miso_i};
                end else cnt_q <= cnt_q + 1'b1;
                FE_HIGH: if (half_end) begin
                    cnt_q  <= '0;
                    sclk_o <= 1'b0;
                    if (last_bit) begin
                        csn_o  <= 1'b1;
                        done_o <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= sh_q << 1;
                    end
                end else cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Observation of pin activity for the timing properties
    logic        sclk_d, csn_d;
    logic [15:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
            run_q  <= '0;
        end else begin
            sclk_d <= sclk_o;
            csn_d  <= csn_o;
            run_q  <= ((sclk_o != sclk_d) || (csn_o != csn_d)) ? 16'd1 : run_q + 16'd1;
        end
    end

    // R3: mode 0, clock low when chip select moves
    p_csn_edge_sclk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_o != csn_d) |-> !sclk_o);
    // R1/R3: clock idles low outside a frame
    p_idle_sclk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sclk_o);
    // R4: each clock level lasts half the divider
    p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_o && (sclk_o != sclk_d)) |-> (run_q == 16'(HALF)));
endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
    import spi_cfg_pkg::*;
#(
    parameter int CLK_DIV    = 32,
    parameter int GAP_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             sclk_o,
    output logic             csn_o,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             done_o,
    output logic             error_o,
    output logic [IDX_W-1:0] err_idx_o
);
    localparam int GAP_W = $clog2(GAP_CYCLES) + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_LEN - 1);

    seq_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q, chk_idx;
    logic [GAP_W-1:0] gap_q;
    logic             go_q, fr_done, echo_bad, gap_end;
    logic [CMD_W-1:0] tx_word, rx_word;

    assign chk_idx = idx_q - IDX_W'(FIRST_WR);
    assign gap_end = (gap_q == GAP_W'(GAP_CYCLES - 1));

    spi_cfg_rom u_rom (
        .tx_idx_i  (idx_q),
        .chk_idx_i (chk_idx),
        .chk_en_i  (idx_q >= IDX_W'(FIRST_WR)),
        .rx_i      (rx_word),
        .tx_word_o (tx_word),
        .echo_bad_o(echo_bad)
    );

    spi_word_engine #(.W(CMD_W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (go_q),
        .tx_i  (tx_word),
        .miso_i(miso_i),
        .sclk_o(sclk_o),
        .csn_o (csn_o),
        .mosi_o(mosi_o),
        .done_o(fr_done),
        .rx_o  (rx_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (start_i) st_d = SQ_SEND;
            SQ_SEND: if (fr_done) st_d = (idx_q == LAST_IDX) ? SQ_IDLE : SQ_GAP;
            SQ_GAP:  if (gap_end) st_d = SQ_SEND;
            default:              st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            gap_q     <= '0;
            go_q      <= 1'b0;
            done_o    <= 1'b0;
            error_o   <= 1'b0;
            err_idx_o <= '0;
        end else begin
            go_q   <= 1'b0;
            done_o <= 1'b0;
            unique case (st_q)
                SQ_IDLE: if (start_i) begin
                    idx_q     <= '0;
                    go_q      <= 1'b1;
                    error_o   <= 1'b0;
                    err_idx_o <= '0;
                end
                SQ_SEND: if (fr_done) begin
                    if (echo_bad && !error_o) begin
                        error_o   <= 1'b1;
                        err_idx_o <= chk_idx;
                    end
                    gap_q <= '0;
                    if (idx_q == LAST_IDX) done_o <= 1'b1;
                end
                SQ_GAP: if (gap_end) begin
                    idx_q <= idx_q + 1'b1;
                    go_q  <= 1'b1;
                end else gap_q <= gap_q + 1'b1;
                default: ;
            endcase
        end
    end

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: done follows the end of the last frame by one clock
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csn_o) && idx_q == LAST_IDX) |=> done_o);
    // R7: once set during a run, error stays set
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && st_q != SQ_IDLE) |=> error_o);
    // R7: the recorded index never moves after the first mismatch
    p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && st_q != SQ_IDLE) |=> $stable(err_idx_o));
    // R10: start during a run cannot clear error
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SQ_IDLE && start_i && error_o) |=> error_o);
endmodule

// File: tb/spi_cfg_seq_test.sv
module spi_cfg_seq_test;
    localparam int CDIV = 4;
    localparam int GAP  = 3;
    localparam int HALF = CDIV / 2;
    localparam int NW   = 30;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
    logic sclk, csn, mosi, done, err;
    logic [4:0] eidx;

    spi_cfg_seq #(.CLK_DIV(CDIV), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_o(sclk), .csn_o(csn),
        .mosi_o(mosi), .miso_i(miso), .done_o(done), .error_o(err), .err_idx_o(eidx)
    );

    always #2 clk = ~clk;  // 250 MHz

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data(input int r);
        case (r)
            0: return 8'hDE;  1: return 8'h20;  2: return 8'h28;  3: return 8'h02;
            4: return 8'h90;  8: return 8'h2C;  9: return 8'h11; 10: return 8'h08;
            11: return 8'h15; 12: return 8'h36;
            14, 15, 16, 17: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_word(input int i);
        if (i >= 2 && i <= 19) return {8'h80 | 8'(i - 2), exp_data(i - 2)};
        if (i == 20) return 16'h5500;
        return 16'hFF00;
    endfunction

    // Peripheral model: answers command k-2 during frame k
    logic [15:0] cap [NW];
    int          bits [NW];
    int          fno = 0, bitcnt = 0, opos = -1;
    logic [15:0] shin = '0, outw = '0, fault_xor = 16'h0001;
    logic [29:0] fault_mask = '0;

    always @(negedge csn) begin
        logic [15:0] c;
        outw = 16'($urandom);
        if (fno >= 2 && fno < NW) begin
            c = cap[fno - 2];
            if (c[15:14] == 2'b10)
                outw = {8'hFF, c[7:0]} ^ (fault_mask[fno - 2] ? fault_xor : 16'h0000);
        end
        miso = outw[15];
        opos = 14;
        shin = '0;
        bitcnt = 0;
    end
    always @(negedge sclk) if (!csn && opos >= 0) begin miso = outw[opos]; opos--; end
    always @(posedge sclk) if (!csn) begin shin = {shin[14:0], mosi}; bitcnt++; end
    always @(posedge csn) begin
        if (fno >= 0 && fno < NW) begin cap[fno] = shin; bits[fno] = bitcnt; end
        fno++;
    end

    // Pin timing observer, sampled away from the active edge
    logic csn_p = 1'b1, sclk_p = 1'b0, done_p = 1'b0, have_rise = 1'b0, first_sr = 1'b0;
    int rise_c = 0, fall_c = 0, last_sr = 0;
    int t_bad = 0, gap_bad = 0, sclk_bad = 0, done_cnt = 0, done_bad = 0;
    logic err_at_done = 1'b0;
    logic [4:0] idx_at_done = '0;

    always @(negedge clk) if (rst_n) begin
        if (csn && !csn_p) begin
            rise_c = cyc;
            have_rise = 1'b1;
        end
        if (!csn && csn_p) begin
            fall_c = cyc;
            first_sr = 1'b1;
            if (sclk) sclk_bad++;
            if (have_rise && (cyc - rise_c) != GAP + 2) gap_bad++;
        end
        if (sclk && !sclk_p && !csn) begin
            if (first_sr ? (cyc - fall_c) != HALF : (cyc - last_sr) != CDIV) t_bad++;
            first_sr = 1'b0;
            last_sr = cyc;
        end
        if (done) begin
            done_cnt++;
            if (done_p || (cyc - rise_c) != 1) done_bad++;
            err_at_done = err;
            idx_at_done = eidx;
        end
        csn_p = csn;
        sclk_p = sclk;
        done_p = done;
    end

    task automatic run_seq(input logic [29:0] fmask, input bit extra, input int dly);
        bit exp_err = 1'b0;
        int exp_idx = 0, w = 0, bad_w = 0, bad_b = 0;
        for (int j = 2; j <= 19; j++)
            if (fmask[j] && !exp_err) begin exp_err = 1'b1; exp_idx = j; end
        @(negedge clk);
        fno = 0; done_cnt = 0; t_bad = 0; gap_bad = 0; sclk_bad = 0; done_bad = 0;
        have_rise = 1'b0;
        fault_mask = fmask;
        fault_xor = 16'($urandom) | 16'h0001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b0 && eidx == 5'd0, "R11", "error cleared by start", {err, eidx}, 0);
        if (extra) begin
            repeat (dly) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && w < 20000) begin @(negedge clk); w++; end
        #1;
        check(w < 20000, "R9", "done seen before run timeout", w, 20000);
        repeat (3 * (16 * CDIV + GAP + 4)) @(negedge clk);
        for (int i = 0; i < NW; i++) begin
            if (cap[i] !== exp_word(i)) begin
                if (bad_w == 0) check(0, "R2", $sformatf("word %0d", i), cap[i], exp_word(i));
                bad_w++;
            end
            if (bits[i] != 16) bad_b++;
        end
        check(bad_w == 0, "R2", "script words mismatching", bad_w, 0);
        check(fno == NW, "R2", "frame count", fno, NW);
        check(bad_b == 0 && sclk_bad == 0, "R3", "frames not 16 bits or sclk high at cs edge",
              bad_b + sclk_bad, 0);
        check(t_bad == 0, "R4", "sclk period violations", t_bad, 0);
        check(gap_bad == 0, "R5", "cs gap violations", gap_bad, 0);
        check(done_cnt == 1 && done_bad == 0, "R9", "done pulses / timing faults",
              {done_cnt[15:0], done_bad[15:0]}, 32'h0001_0000);
        check(err_at_done == exp_err, exp_err ? "R6" : "R8", "error at done", err_at_done, exp_err);
        if (exp_err)
            check(idx_at_done == 5'(exp_idx), "R7", "error index", idx_at_done, exp_idx);
        check(err == exp_err, "R9", "error held after done", err, exp_err);
        if (extra)
            check(fno == NW && done_cnt == 1, "R10", "restart ignored (frames,done)",
                  {fno[15:0], done_cnt[15:0]}, {16'(NW), 16'd1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(csn == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "pins in reset",
              {csn, sclk, mosi}, 3'b100);
        check(done == 1'b0 && err == 1'b0 && eidx == 5'd0, "R1", "status in reset",
              {done, err, eidx}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(csn == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1", "idle without start",
              {csn, sclk, done}, 3'b100);

        run_seq(30'h0, 1'b0, 0);                              // clean run: R2..R9
        run_seq(30'h1 << 2, 1'b0, 0);                         // first write corrupted: R6
        run_seq(30'h0, 1'b0, 0);                              // R11 recovery
        run_seq(30'h1 << 19, 1'b0, 0);                        // last write corrupted: R6
        run_seq((30'h1 << 5) | (30'h1 << 12), 1'b0, 0);       // first mismatch wins: R7
        run_seq(30'h3FF0_0003, 1'b0, 0);                      // non-write faults: R8
        run_seq(30'h1 << 7, 1'b1, 30);                        // restart in frame 0: R10
        run_seq(30'h0, 1'b1, 16 * CDIV + 2);                  // restart near a gap: R10
        for (int r = 0; r < 6; r++) begin
            logic [29:0] m;
            m = ($urandom % 3 == 0) ? 30'h0 : (30'($urandom) & 30'($urandom));
            run_seq(m, 1'($urandom), 1 + int'($urandom % 600));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule